// File: doc/BRIEF.md
# Timer Interrupt Status and Enable Register

This block is the interrupt bookkeeping shared by a group of countdown timer channels. Each channel owns one enable bit and one pending bit inside a single 32-bit control/status word. The block drives one level interrupt line per channel. The timer counters sit outside the block. Each counter delivers a one-cycle expiry pulse here. A register port made of a write strobe, write data and combinational read data gives software access to the word.

The low field of the word holds the per-channel enables, bit n for channel n. A write replaces the whole enable field. The pending field sits directly above it, at bit NUM_CH+n for channel n. An expiry marks the channel pending whether or not the channel is enabled. The interrupt line rises only when the expiry arrives while the channel is enabled. Software clears pending bits by writing ones to them; zeros written there have no effect. Clearing a pending bit also drops that channel's interrupt line. All bits above the pending field read as zero, and writes to them are discarded.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset the read data is zero and every interrupt line is low.
- R2: A write loads bits 0 to NUM_CH-1 (channel n at bit n) from the write data, and the new value reads back from the cycle after the write.
- R3: An expiry pulse on channel n sets bit NUM_CH+n (bit 5+n by default) in the cycle after the pulse, enabled or not.
- R4: An expiry on a channel whose enable bit is set before that clock edge raises its interrupt line in the next cycle.
- R5: An expiry on a disabled channel leaves its line low, and setting the enable bit later does not raise the line.
- R6: A write with a one at bit NUM_CH+n clears that pending bit. A zero written there keeps the bit unchanged.
- R7: When a write takes a pending bit from one to zero, that channel's interrupt line is low in the next cycle.
- R8: When an expiry and a clearing write hit the same channel in one cycle, the pending bit stays set. The line is then raised if the channel was enabled and otherwise keeps its value.
- R9: Bits 2*NUM_CH to 31 always read as zero, and writing ones there changes no state.
- R10: Clearing a channel's enable bit does not lower an interrupt line that is already high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control/status word |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Current control/status word (combinational read) |
| expiry_i | input | NUM_CH | One pulse per channel expiry |
| irq_o | output | NUM_CH | Registered level interrupt line per channel |

## Verification
The bench builds the block with its default parameters: five channels and a 32-bit word. This places the pending field at bits 5 to 9 and leaves bits 10 to 31 unused, so the unused field can be exercised. Directed steps reach the orderings that matter: expiry before enable, disable while an interrupt is high, and clear and expiry together on one channel. A long random stretch then mixes writes and expiries on all five channels. Every cycle is compared against a behavioural model.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  // Default geometry of the control/status word
  localparam int unsigned TMR_CH_DEF = 5;
  localparam int unsigned TMR_DW_DEF = 32;

  // Per-channel next-state classification, used for readability in the channel cell
  typedef enum logic [1:0] {
    LINE_HOLD  = 2'd0,
    LINE_RAISE = 2'd1,
    LINE_DROP  = 2'd2
  } line_act_e;
endpackage

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan
  import tmr_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expiry_i,
  input  logic wr_i,
  input  logic en_wd_i,
  input  logic clr_wd_i,
  output logic en_o,
  output logic pend_o,
  output logic irq_o
);

  logic en_q, pend_q, irq_q;

  // Named internal events, visible to the assertions
  logic      ev_raise;
  logic      ev_clear_req;
  logic      ev_pend_fall;
  line_act_e line_act;

  function automatic logic pend_next(input logic cur, input logic clr, input logic exp);
    return (cur & ~clr) | exp;
  endfunction

  function automatic line_act_e line_decide(input logic raise, input logic fall);
    if (raise)     return LINE_RAISE;
    else if (fall) return LINE_DROP;
    else           return LINE_HOLD;
  endfunction

  assign ev_clear_req = wr_i & clr_wd_i;
  assign ev_raise     = expiry_i & en_q;
  assign ev_pend_fall = pend_q & ev_clear_req & ~expiry_i;
  assign line_act     = line_decide(ev_raise, ev_pend_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_i) en_q <= en_wd_i;
      pend_q <= pend_next(pend_q, ev_clear_req, expiry_i);
      case (line_act)
        LINE_RAISE: irq_q <= 1'b1;
        LINE_DROP:  irq_q <= 1'b0;
        default:    irq_q <= irq_q;
      endcase
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  assert_exp_sets_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expiry_i |=> pend_o);
  assert_irq_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expiry_i && en_o) |=> irq_o);
  assert_no_spurious_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !(expiry_i && en_o)) |=> !irq_o);
  assert_clear_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && clr_wd_i && !expiry_i) |=> !pend_o);
  assert_keep_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !(wr_i && clr_wd_i)) |=> pend_o);
  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && wr_i && clr_wd_i && !expiry_i) |=> !irq_o);
  assert_expiry_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expiry_i && wr_i && clr_wd_i) |=> pend_o);
  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(pend_o && wr_i && clr_wd_i && !expiry_i)) |=> irq_o);
  assert_en_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_o == $past(en_wd_i)));

endmodule

// File: rtl/tmr_irq_regmap.sv
module tmr_irq_regmap #(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] pend_i,
  output logic [NUM_CH-1:0] en_wd_o,
  output logic [NUM_CH-1:0] clr_wd_o,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int unsigned PEND_LSB = NUM_CH;
  localparam int unsigned USED_W   = 2 * NUM_CH;

  function automatic logic [NUM_CH-1:0] field_en(input logic [DATA_W-1:0] w);
    return w[NUM_CH-1:0];
  endfunction

  function automatic logic [NUM_CH-1:0] field_pend(input logic [DATA_W-1:0] w);
    return w[PEND_LSB +: NUM_CH];
  endfunction

  function automatic logic [DATA_W-1:0] pack_word(input logic [NUM_CH-1:0] en,
                                                 input logic [NUM_CH-1:0] pend);
    logic [DATA_W-1:0] w;
    w = '0;
    w[NUM_CH-1:0]           = en;
    w[PEND_LSB +: NUM_CH]   = pend;
    return w;
  endfunction

  assign en_wd_o   = field_en(wr_data_i);
  assign clr_wd_o  = field_pend(wr_data_i);
  assign rd_data_o = pack_word(en_i, pend_i);

  // R9: unused upper field must read zero whatever was written
  generate
    if (USED_W < DATA_W) begin : g_upper_chk
      always_comb begin
        assert_upper_zero_R9: assert (rd_data_o[DATA_W-1:USED_W] == '0);
      end
    end
  endgenerate

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = TMR_CH_DEF,
  parameter int unsigned DATA_W = TMR_DW_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [NUM_CH-1:0] expiry_i,
  output logic [NUM_CH-1:0] irq_o
);

  logic [NUM_CH-1:0] en_wd, clr_wd, en_q, pend_q;

  tmr_irq_regmap #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regmap (
    .wr_data_i (wr_data_i),
    .en_i      (en_q),
    .pend_i    (pend_q),
    .en_wd_o   (en_wd),
    .clr_wd_o  (clr_wd),
    .rd_data_o (rd_data_o)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      tmr_irq_chan u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .expiry_i (expiry_i[c]),
        .wr_i     (wr_en_i),
        .en_wd_i  (en_wd[c]),
        .clr_wd_i (clr_wd[c]),
        .en_o     (en_q[c]),
        .pend_o   (pend_q[c]),
        .irq_o    (irq_o[c])
      );
    end
  endgenerate

  assert_stable_no_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && expiry_i == '0) |=> $stable(rd_data_o));
  assert_irq_implies_seen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o[0])) |-> $past(expiry_i[0]));

endmodule

// File: tb/tmr_irq_ctrl_tb_top.sv
module tmr_irq_ctrl_tb_top;
  localparam int NCH = 5;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NCH-1:0] expiry = '0;
  logic [NCH-1:0] irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state as plain integers
  int m_en = 0, m_pend = 0, m_irq = 0;

  always #4 clk = ~clk;

  tmr_irq_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .expiry_i  (expiry),
    .irq_o     (irq)
  );

  task automatic check(string tag, int act, int exp_v, string what);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp_v);
    end
  endtask

  task automatic compare(string tag);
    check(tag, int'(rd_data), (m_pend << 5) | m_en, "rd_data");
    check(tag, int'(irq), m_irq, "irq");
  endtask

  // drive one cycle from a negedge, update the model, compare at the next negedge
  task automatic step(string tag, bit wr, int wd, int ex);
    int clr, fall, n_en, n_pend, n_irq;
    wr_en   = wr;
    wr_data = wd;
    expiry  = ex[NCH-1:0];
    clr    = wr ? ((wd >> 5) & 31) : 0;
    fall   = m_pend & clr & ~ex & 31;
    n_pend = ((m_pend & ~clr) | ex) & 31;
    n_irq  = ((m_irq & ~fall) | (ex & m_en)) & 31;
    n_en   = wr ? (wd & 31) : m_en;
    @(posedge clk);
    @(negedge clk);
    m_en = n_en; m_pend = n_pend; m_irq = n_irq;
    wr_en = 1'b0; expiry = '0;
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    step("R2", 1, 32'h15, 0);
    step("R2", 1, 32'h00, 0);
    step("R3", 0, 0, 5'b00010);          // ch1 disabled: pend bit 6
    step("R5", 1, 32'h02, 0);            // enable ch1 afterwards, no irq
    step("R5", 0, 0, 0);
    step("R4", 0, 0, 5'b00010);          // ch1 enabled now: irq1 rises
    step("R10", 1, 32'h00, 0);           // disable ch1, irq1 stays
    step("R10", 0, 0, 0);
    step("R6", 1, 32'h0, 0);             // zeros on pending keep it
    step("R7", 1, 32'h40, 0);            // clear bit 6: pend and irq1 drop
    step("R8", 1, 32'h04, 0);            // enable ch2
    step("R8", 1, 32'h84, 5'b00100);     // clear + expiry same cycle, enabled
    step("R8", 1, 32'h100, 5'b01000);    // ch3 disabled, clear + expiry
    step("R6", 1, 32'h1E0, 0);           // clear everything pending
    step("R9", 1, 32'hFFFF_FC00, 0);     // upper bits ignored
    step("R9", 1, 32'hFFFF_FC1F, 5'b11111);
    step("R9", 1, 32'hFFFF_FFFF, 0);
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom;
      step("R6", (r & 7) == 0, $urandom, ($urandom % 4 == 0) ? ($urandom & 31) : 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule